// File: doc/BRIEF.md
# Prioritized Multi-Source Reset Controller

This block turns five independent reset requests into the reset outputs of a chip: a system reset, one reset per switchable power domain, a reset for the always-on clock domain and a reset-out pin. The requests are a cold-reset pin, a warm-reset pin, a watchdog timeout, a keyed software write and per-domain wakeup events. The two pins and the watchdog line are asynchronous, so each passes through a two-stage synchronizer before use. Register-side writes and the wakeup and sleep inputs come from the same clock domain as the block.

When several requests are present in the same cycle, a fixed ranking picks the one that is recorded. Every accepted system request holds the reset low for a fixed number of extra cycles after the request disappears. A cold request also has to persist for a minimum number of synchronized cycles before it counts. Wakeup resets reach only the domains that need them. Outside sleep mode that means the domains built from ordinary flip-flops. In sleep mode it means every domain that wakes. A small status register keeps a one-hot record of the cause that won the last reset.

The controller's own power-on input `rst_ni` clears it asynchronously. All outputs leave that state synchronously to the clock.

Top module: `rst_prio_ctrl`

## Requirements
- R1: While `rst_ni` is low, `sys_rst_n_o`, every `dom_rst_n_o` bit, `rtc_rst_n_o` and `rst_out_n_o` are low and `cause_o` is zero. After release, `rtc_rst_n_o` rises after two clock edges, and the system reset stays low for STRETCH+1 edges.
- R2: `cause_o` is one-hot: bit 0 cold, bit 1 watchdog, bit 2 warm, bit 3 software, bit 4 wakeup. The ranking from highest to lowest is cold, watchdog, warm, software, wakeup. When requests coincide, the highest ranked is recorded. A higher-ranked request that arrives during a running system reset overwrites the record. A lower-ranked one does not.
- R3: A cold pin held low for L synchronized cycles with L ≥ MIN_COLD drives `sys_rst_n_o` low for L−MIN_COLD+1+STRETCH cycles and records cold. With L < MIN_COLD there is no system reset and the record is unchanged.
- R4: `rtc_rst_n_o` stays high during every cold, watchdog, warm, software and wakeup reset.
- R5: `rst_out_n_o` is low for exactly as many cycles as the cold pin is low, three cycles later, independent of MIN_COLD.
- R6: A warm pin (active low) or watchdog line (active high) held for L cycles drives `sys_rst_n_o` low for L+STRETCH cycles, reaching the core two cycles after the pin.
- R7: A write with `reg_sel_i`=0 and data equal to SW_KEY gives a system reset of 1+STRETCH cycles and records software. Any other data has no effect.
- R8: Whenever `sys_rst_n_o` is low, every `dom_rst_n_o` bit is low.
- R9: Outside sleep, a one-cycle `wake_i[d]` drives `dom_rst_n_o[d]` low for 1+STRETCH cycles only if RETAIN[d]=0. It leaves the other domains and `sys_rst_n_o` high and records wakeup. With RETAIN[d]=1 nothing happens.
- R10: With `sleep_i` high, every domain whose `wake_i` bit pulses gets the 1+STRETCH wakeup reset, whatever its RETAIN bit.
- R11: A write with `reg_sel_i`=1 clears the `cause_o` bits set in `reg_wdata_i[4:0]` and leaves the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Power-on reset of the controller, active low, asynchronous |
| cold_n_i | input | 1 | Cold-reset pin, active low, asynchronous |
| warm_n_i | input | 1 | Warm-reset pin, active low, asynchronous |
| wdog_i | input | 1 | Watchdog timeout, active high, asynchronous |
| sleep_i | input | 1 | Chip is in sleep mode |
| wake_i | input | N_DOM | Per-domain power-up event, one-cycle pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 = control (software key), 1 = status clear |
| reg_wdata_i | input | DATA_W | Register write data |
| cause_o | output | 5 | One-hot cause of the last reset |
| sys_rst_n_o | output | 1 | System reset, active low |
| dom_rst_n_o | output | N_DOM | Per-domain resets, active low |
| rtc_rst_n_o | output | 1 | Always-on domain reset, active low |
| rst_out_n_o | output | 1 | Reset-out pin, active low |

## Verification
The bench builds the block with MIN_COLD=3, STRETCH=5, four domains, RETAIN=4'b1010 and key 8'h5A. These short windows let every cold pulse land on either side of the filter threshold, with both the accepted and the rejected length tried. A late cold request can overtake a warm sequence before its stretch expires. The mixed retention mask means one wakeup vector, with and without sleep, sorts domains into reset and untouched groups. Random subsets of simultaneous requests test the ranking.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  localparam int unsigned NCAUSE = 5;
  typedef logic [NCAUSE-1:0] cause_t;
  // lower bit index = higher rank
  localparam cause_t CAUSE_COLD = 5'b00001;
  localparam cause_t CAUSE_WDOG = 5'b00010;
  localparam cause_t CAUSE_WARM = 5'b00100;
  localparam cause_t CAUSE_SOFT = 5'b01000;
  localparam cause_t CAUSE_WAKE = 5'b10000;
endpackage

// File: rtl/rpc_sync.sv
module rpc_sync #(
  parameter int unsigned   W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/rpc_cold_filter.sv
module rpc_cold_filter #(
  parameter int unsigned MIN_COLD = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cold_s_n_i,
  output logic valid_o
);
  localparam int unsigned    CW  = $clog2(MIN_COLD + 1);
  localparam logic [CW-1:0]  SAT = CW'(MIN_COLD - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = cold_s_n_i | (cnt_q != SAT);
    if (cold_s_n_i) cnt_d = '0;
    else            cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign valid_o = ~cold_s_n_i & (cnt_q == SAT);
endmodule

// File: rtl/rpc_arb.sv
module rpc_arb #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] req_i,
  output logic [W-1:0] gnt_o
);
  // isolate lowest set bit: index 0 has the highest rank
  assign gnt_o = req_i & (~req_i + 1'b1);
endmodule

// File: rtl/rpc_wake.sv
module rpc_wake #(
  parameter int unsigned       N_DOM   = 4,
  parameter int unsigned       STRETCH = 32,
  parameter logic [N_DOM-1:0]  RETAIN  = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_i,
  input  logic [N_DOM-1:0] wake_i,
  input  logic             sys_lo_i,
  output logic [N_DOM-1:0] dom_rst_n_o,
  output logic             hit_o
);
  localparam int unsigned    SW        = $clog2(STRETCH + 1);
  localparam logic [SW-1:0]  STRETCH_V = SW'(STRETCH);

  logic [N_DOM-1:0] elig_v;

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    logic          elig;
    logic [SW-1:0] cnt_q, cnt_d;
    logic          rst_n_q;

    always_comb begin
      elig = wake_i[d] & (sleep_i | ~RETAIN[d]);
      if (elig)                cnt_d = STRETCH_V;
      else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
      else                     cnt_d = cnt_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q   <= '0;
        rst_n_q <= 1'b0;
      end else begin
        cnt_q   <= cnt_d;
        rst_n_q <= ~(sys_lo_i | elig | (cnt_q != '0));
      end
    end

    assign elig_v[d]      = elig;
    assign dom_rst_n_o[d] = rst_n_q;
  end

  assign hit_o = |elig_v;
endmodule

// File: rtl/rst_prio_ctrl.sv
module rst_prio_ctrl
  import rpc_pkg::*;
#(
  parameter int unsigned        N_DOM    = 4,
  parameter int unsigned        MIN_COLD = 16,
  parameter int unsigned        STRETCH  = 32,
  parameter int unsigned        DATA_W   = 8,
  parameter logic [DATA_W-1:0]  SW_KEY   = DATA_W'(8'hC3),
  parameter logic [N_DOM-1:0]   RETAIN   = N_DOM'(4'b0110)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cold_n_i,
  input  logic              warm_n_i,
  input  logic              wdog_i,
  input  logic              sleep_i,
  input  logic [N_DOM-1:0]  wake_i,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [NCAUSE-1:0] cause_o,
  output logic              sys_rst_n_o,
  output logic [N_DOM-1:0]  dom_rst_n_o,
  output logic              rtc_rst_n_o,
  output logic              rst_out_n_o
);
  localparam int unsigned    SCW       = $clog2(STRETCH + 1);
  localparam logic [SCW-1:0] STRETCH_V = SCW'(STRETCH);

  logic [2:0]     pin_s;
  logic           cold_s_n, warm_s_n, wdog_s, cold_ok;
  logic           rtc_q;
  logic [3:0]     req4, gnt4;
  cause_t         win;
  logic           sys_req, sys_lo_d, take_sys, key_wr, clr_wr, wake_hit;
  logic           sw_pend_q, sys_rst_n_q, rst_out_q;
  logic [SCW-1:0] cnt_q, cnt_d;
  cause_t         status_q, status_d, cur_q, cur_d;

  // asynchronous sources: {watchdog, warm_n, cold_n}
  rpc_sync #(.W(3), .RST_VAL(3'b011)) u_pin_sync (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .d_i   ({wdog_i, warm_n_i, cold_n_i}),
    .q_o   (pin_s)
  );
  assign cold_s_n = pin_s[0];
  assign warm_s_n = pin_s[1];
  assign wdog_s   = pin_s[2];

  rpc_sync #(.W(1), .RST_VAL(1'b0)) u_rtc_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (1'b1), .q_o (rtc_q)
  );

  rpc_cold_filter #(.MIN_COLD(MIN_COLD)) u_cold (
    .clk_i (clk_i), .rst_ni (rst_ni), .cold_s_n_i (cold_s_n), .valid_o (cold_ok)
  );

  assign req4 = {sw_pend_q, ~warm_s_n, wdog_s, cold_ok};

  rpc_arb #(.W(4)) u_arb (.req_i (req4), .gnt_o (gnt4));

  rpc_wake #(.N_DOM(N_DOM), .STRETCH(STRETCH), .RETAIN(RETAIN)) u_wake (
    .clk_i (clk_i), .rst_ni (rst_ni), .sleep_i (sleep_i), .wake_i (wake_i),
    .sys_lo_i (sys_lo_d), .dom_rst_n_o (dom_rst_n_o), .hit_o (wake_hit)
  );

  // next-state logic
  always_comb begin
    key_wr   = reg_we_i & ~reg_sel_i & (reg_wdata_i == SW_KEY);
    clr_wr   = reg_we_i & reg_sel_i;
    win      = {1'b0, gnt4};
    sys_req  = |req4;
    sys_lo_d = sys_req | (cnt_q != '0);

    if (sys_req)             cnt_d = STRETCH_V;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    else                     cnt_d = cnt_q;

    take_sys = sys_req & ((cur_q == '0) | (win < cur_q));

    status_d = status_q;
    if (clr_wr) status_d = status_q & ~reg_wdata_i[NCAUSE-1:0];
    if (take_sys)                               status_d = win;
    else if (wake_hit & ~sys_req & sys_rst_n_q) status_d = CAUSE_WAKE;

    if (!sys_lo_d)     cur_d = '0;
    else if (take_sys) cur_d = win;
    else               cur_d = cur_q;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_pend_q   <= 1'b0;
      cnt_q       <= STRETCH_V;
      sys_rst_n_q <= 1'b0;
      rst_out_q   <= 1'b0;
      status_q    <= '0;
      cur_q       <= '0;
    end else begin
      sw_pend_q   <= key_wr;
      cnt_q       <= cnt_d;
      sys_rst_n_q <= ~sys_lo_d;
      rst_out_q   <= cold_s_n;
      status_q    <= status_d;
      cur_q       <= cur_d;
    end
  end

  assign cause_o     = status_q;
  assign sys_rst_n_o = sys_rst_n_q;
  assign rtc_rst_n_o = rtc_q;
  assign rst_out_n_o = rst_out_q;
endmodule

// File: rtl/rst_prio_ctrl_chk.sv
module rst_prio_ctrl_chk #(
  parameter int unsigned      N_DOM  = 4,
  parameter logic [N_DOM-1:0] RETAIN = '0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sleep_i,
  input logic [N_DOM-1:0] wake_i,
  input logic [4:0]       cause_o,
  input logic             sys_rst_n_o,
  input logic [N_DOM-1:0] dom_rst_n_o,
  input logic             rtc_rst_n_o,
  input logic             rst_out_n_o,
  input logic             cold_s_n,
  input logic             cold_ok,
  input logic             sys_req
);
  a_r8_dom_follow_sys: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_rst_n_o |-> (dom_rst_n_o == '0));

  a_r2_cause_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cause_o));

  a_r3_cold_records: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cold_ok |=> (cause_o == 5'b00001));

  a_r5_out_tracks_cold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cold_s_n |=> !rst_out_n_o);

  a_r4_rtc_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_out_n_o) |-> rtc_rst_n_o);

  a_r6_req_asserts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_req |=> !sys_rst_n_o);

  for (genvar d = 0; d < N_DOM; d++) begin : g_wk
    a_r9_wake_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wake_i[d] && (sleep_i || !RETAIN[d])) |=> !dom_rst_n_o[d]);
  end
endmodule

bind rst_prio_ctrl rst_prio_ctrl_chk #(.N_DOM(N_DOM), .RETAIN(RETAIN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sleep_i     (sleep_i),
  .wake_i      (wake_i),
  .cause_o     (cause_o),
  .sys_rst_n_o (sys_rst_n_o),
  .dom_rst_n_o (dom_rst_n_o),
  .rtc_rst_n_o (rtc_rst_n_o),
  .rst_out_n_o (rst_out_n_o),
  .cold_s_n    (cold_s_n),
  .cold_ok     (cold_ok),
  .sys_req     (sys_req)
);

// File: tb/rst_prio_ctrl_test.sv
module rst_prio_ctrl_test;
  localparam int unsigned N   = 4;
  localparam int          MC  = 3;
  localparam int          ST  = 5;
  localparam logic [7:0]  KEY = 8'h5A;
  localparam logic [N-1:0] RET = 4'b1010;
  localparam int          WIN = 40;

  logic clk = 1'b0;
  logic rst_n;
  logic cold_n, warm_n, wdog, sleep, reg_we, reg_sel;
  logic [N-1:0] wake;
  logic [7:0]   wdata;
  logic [4:0]   cause;
  logic         sys_n, rtc_n, out_n;
  logic [N-1:0] dom_n;

  always #2 clk = ~clk;

  rst_prio_ctrl #(.N_DOM(N), .MIN_COLD(MC), .STRETCH(ST), .DATA_W(8),
                  .SW_KEY(KEY), .RETAIN(RET)) uut (
    .clk_i (clk), .rst_ni (rst_n), .cold_n_i (cold_n), .warm_n_i (warm_n),
    .wdog_i (wdog), .sleep_i (sleep), .wake_i (wake), .reg_we_i (reg_we),
    .reg_sel_i (reg_sel), .reg_wdata_i (wdata), .cause_o (cause),
    .sys_rst_n_o (sys_n), .dom_rst_n_o (dom_n), .rtc_rst_n_o (rtc_n),
    .rst_out_n_o (out_n)
  );

  int nchk = 0, nfail = 0;
  int st [5];
  int ln [5];
  int c_sys, c_out, c_rtc;
  int c_dom [N];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic sel, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = sel; wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic clear_src();
    for (int i = 0; i < 5; i++) begin st[i] = 0; ln[i] = 0; end
  endtask

  // drive one stimulus window, count low cycles of each output
  task automatic run(input logic [7:0] key, input logic [N-1:0] wk, input logic slp);
    c_sys = 0; c_out = 0; c_rtc = 0;
    for (int d = 0; d < N; d++) c_dom[d] = 0;
    for (int c = 0; c < WIN; c++) begin
      @(negedge clk);
      if (!sys_n) c_sys++;
      if (!out_n) c_out++;
      if (!rtc_n) c_rtc++;
      for (int d = 0; d < N; d++) if (!dom_n[d]) c_dom[d]++;
      sleep  = slp;
      cold_n = !(ln[0] > 0 && c >= st[0] && c < st[0] + ln[0]);
      wdog   =  (ln[1] > 0 && c >= st[1] && c < st[1] + ln[1]);
      warm_n = !(ln[2] > 0 && c >= st[2] && c < st[2] + ln[2]);
      reg_we = (ln[3] > 0 && c == st[3]);
      reg_sel = 1'b0;
      wdata  = key;
      wake   = (ln[4] > 0 && c == st[4]) ? wk : '0;
    end
    @(negedge clk);
    sleep = 1'b0;
  endtask

  function automatic logic [4:0] lowest(input logic [4:0] v);
    return v & (~v + 5'd1);
  endfunction

  task automatic run_all();
    int L;
    logic [4:0] sub, expc;
    logic [N-1:0] wk, elig;
    logic slp;

    // R1 power-on state
    rst_n = 1'b0; cold_n = 1; warm_n = 1; wdog = 0; sleep = 0;
    wake = '0; reg_we = 0; reg_sel = 0; wdata = 0;
    repeat (3) @(negedge clk);
    check(sys_n == 0 && dom_n == '0 && rtc_n == 0 && out_n == 0, "R1 outputs in reset",
          {sys_n, rtc_n, out_n}, 0);
    check(cause == 0, "R1 cause cleared", cause, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(rtc_n == 1, "R1 rtc release", rtc_n, 1);
    check(sys_n == 0, "R1 sys stretched", sys_n, 0);
    repeat (ST + 2) @(negedge clk);
    check(sys_n == 1 && dom_n == '1 && out_n == 1, "R1 all released",
          {sys_n, out_n}, 3);

    // R6 warm pin
    clear_src(); ln[2] = 4; run(KEY, '0, 0);
    check(c_sys == 4 + ST, "R6 warm width", c_sys, 4 + ST);
    check(c_dom[3] == 4 + ST, "R8 domain follows warm", c_dom[3], 4 + ST);
    check(c_rtc == 0, "R4 rtc untouched by warm", c_rtc, 0);
    check(cause == 5'b00100, "R2 warm cause", cause, 5'b00100);

    // R11 W1C
    reg_wr(1'b1, 8'h01);
    check(cause == 5'b00100, "R11 clear other bit no effect", cause, 5'b00100);
    reg_wr(1'b1, 8'h04);
    check(cause == 5'b00000, "R11 clear own bit", cause, 0);

    // R6 watchdog
    clear_src(); ln[1] = 7; run(KEY, '0, 0);
    check(c_sys == 7 + ST, "R6 watchdog width", c_sys, 7 + ST);
    check(cause == 5'b00010, "R2 watchdog cause", cause, 5'b00010);

    // R7 software key and wrong key
    reg_wr(1'b1, 8'h1F);
    clear_src(); ln[3] = 1; st[3] = 1; run(KEY ^ 8'h01, '0, 0);
    check(c_sys == 0, "R7 wrong key ignored", c_sys, 0);
    check(cause == 0, "R7 wrong key no cause", cause, 0);
    run(KEY, '0, 0);
    check(c_sys == 1 + ST, "R7 software width", c_sys, 1 + ST);
    check(cause == 5'b01000, "R7 software cause", cause, 5'b01000);

    // R3 / R5 cold pin
    reg_wr(1'b1, 8'h1F);
    clear_src(); ln[0] = MC - 1; run(KEY, '0, 0);
    check(c_sys == 0, "R3 short cold rejected", c_sys, 0);
    check(cause == 0, "R3 short cold no cause", cause, 0);
    check(c_out == MC - 1, "R5 out follows short cold", c_out, MC - 1);
    for (int k = 0; k < 3; k++) begin
      L = MC + k * 3;
      clear_src(); ln[0] = L; run(KEY, '0, 0);
      check(c_sys == L - MC + 1 + ST, "R3 cold width", c_sys, L - MC + 1 + ST);
      check(c_out == L, "R5 out width", c_out, L);
      check(c_rtc == 0, "R4 rtc untouched by cold", c_rtc, 0);
      check(cause == 5'b00001, "R3 cold cause", cause, 5'b00001);
    end

    // R2 preemption and non-preemption
    clear_src(); ln[2] = 10; st[0] = 3; ln[0] = MC + 2; run(KEY, '0, 0);
    check(cause == 5'b00001, "R2 cold preempts warm", cause, 5'b00001);
    clear_src(); ln[2] = 8; st[3] = 5; ln[3] = 1; run(KEY, '0, 0);
    check(cause == 5'b00100, "R2 software keeps warm", cause, 5'b00100);

    // R9 / R10 wakeup directed
    reg_wr(1'b1, 8'h1F);
    clear_src(); st[4] = 2; ln[4] = 1; run(KEY, 4'b0001, 0);
    check(c_dom[0] == 1 + ST && c_dom[1] == 0 && c_sys == 0, "R9 ordinary domain",
          c_dom[0], 1 + ST);
    check(c_rtc == 0, "R4 rtc untouched by wakeup", c_rtc, 0);
    check(cause == 5'b10000, "R9 wake cause", cause, 5'b10000);
    reg_wr(1'b1, 8'h1F);
    run(KEY, 4'b0010, 0);
    check(c_dom[1] == 0 && cause == 0, "R9 retention domain ignored", c_dom[1], 0);
    run(KEY, 4'b1010, 1);
    check(c_dom[1] == 1 + ST && c_dom[3] == 1 + ST && c_dom[0] == 0, "R10 sleep wake",
          c_dom[3], 1 + ST);

    // R2 random request subsets
    for (int it = 0; it < 24; it++) begin
      sub = 5'($urandom_range(1, 31));
      L = MC + int'($urandom_range(0, 3));
      reg_wr(1'b1, 8'h1F);
      clear_src();
      if (sub[0]) ln[0] = L;
      if (sub[1]) ln[1] = L;
      if (sub[2]) ln[2] = L;
      if (sub[3]) begin ln[3] = 1; st[3] = 1; end
      if (sub[4]) begin ln[4] = 1; st[4] = 2; end
      run(KEY, 4'b0001, 0);
      expc = lowest(sub);
      check(cause == expc, "R2 random priority", cause, expc);
    end

    // R9 / R10 random wakeup
    for (int it = 0; it < 16; it++) begin
      wk  = N'($urandom_range(1, 15));
      slp = 1'($urandom_range(0, 1));
      elig = wk & (slp ? '1 : ~RET);
      reg_wr(1'b1, 8'h1F);
      clear_src(); st[4] = 2; ln[4] = 1;
      run(KEY, wk, slp);
      for (int d = 0; d < N; d++)
        check(c_dom[d] == (elig[d] ? 1 + ST : 0), slp ? "R10 random sleep" : "R9 random",
              c_dom[d], elig[d] ? 1 + ST : 0);
      check(c_sys == 0, "R9 no system reset", c_sys, 0);
      check(cause == ((elig != '0) ? 5'b10000 : 5'b00000), "R9 wake record", cause,
            (elig != '0) ? 16 : 0);
    end
  endtask

  initial begin
    void'($urandom(32'd1357));
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule